// File: doc/BRIEF.md
# Serial Dongle Configuration Master

This block sits on the host side of an infrared transceiver dongle. It reads and writes the dongle's indexed configuration registers over a slow serial link. The link has a clock output, a data output, a data input and an active-low read-valid input. The host starts a transfer with a one-cycle strobe. The strobe carries an operation code, a register index and a write byte. The block then sends the whole exchange on its own, raises a busy flag for as long as the exchange runs, and pulses a done flag when it ends. The byte that a read returns stays on a read-data port until the next read finishes.

Every bit on the link lives in one slot. A slot has a low clock phase of two time units, during which the data line is set up, and then a high clock phase of one time unit. One time unit is a programmable number of system clocks. A transfer begins with a start slot and a command byte. The command byte packs a fixed device address, the register index and the direction. What follows depends on the operation:

- A write sends the data byte and a short trailer.
- A read searches a bounded number of slots for the dongle's acknowledgement, then collects eight bits.
- A reset operation sends a long train of clock pulses with the data line low.
- A setup operation chains a reset, three register writes and a read-back. This puts the dongle into a requested mode with a single strobe.

Top module: `dcfg_master`

## Requirements
- R1: The command byte is 0x40 OR (index << 1) OR the direction bit in bit 0, where 1 means write and 0 means read. It is sent as the first byte after the start slot.
- R2: The time unit is cfg_presc+1 system clocks. Every slot holds the clock low for 2 units and then high for 1 unit. The data line changes only at the falling clock edge that begins a slot, so it is stable while the clock is high. Bytes go out least significant bit first.
- R3: Every read and write begins with one start slot that has the data line low.
- R4: A write sends the start slot, the command byte, the data byte (LSB first) and then 2 slots with data low, for 19 clock pulses in total. Afterwards the clock and the data line are both low.
- R5: After a read command the block runs up to 10 search slots with data high. At the end of each search slot's low phase it tests dg_rvalid_n. When dg_rvalid_n reads 0, that slot's pulse completes and 8 data slots follow with data high. dg_din is captured at the end of each data slot's low phase, LSB first.
- R6: If dg_rvalid_n never reads 0 in the 10 search slots, the block sends 2 dummy slots with data high and returns 0x00 as the read byte.
- R7: Every read ends with 1 slot with data high and then 3 slots with data low, after which the clock and the data line are low.
- R8: A reset operation sends 30 slots with data low and no command byte.
- R9: A setup operation runs these steps in order: a reset, a write of 0x17 to index 0, a write of host_wdata (the mode) to index 1, a write of 0xFF to index 2, and a read of index 1. host_rdata receives the byte read back.
- R10: host_busy rises in the cycle after an accepted strobe and stays high until the last slot of the operation ends. host_done is high for exactly the one cycle in which host_busy has just fallen.
- R11: A host_start strobe that arrives while host_busy is high is ignored. It causes no extra link traffic and does not change host_rdata.
- R12: host_rdata is reset to 0x00. It changes only when a read or a setup operation completes, and write and reset operations leave it unchanged.
- R13: host_op encodes the operation: 2'b00 read, 2'b01 write, 2'b10 reset, 2'b11 setup.
- R14: dg_din and dg_rvalid_n pass through a two-flop synchronizer before use. A level that is stable from the preceding rising clock edge is the level that gets sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_presc | input | PRESC_W | Time unit length minus one, in system clocks |
| host_start | input | 1 | One-cycle request strobe |
| host_op | input | 2 | Operation code |
| host_idx | input | 5 | Register index |
| host_wdata | input | 8 | Write byte, or the mode byte for setup |
| host_rdata | output | 8 | Last byte returned by a read |
| host_busy | output | 1 | Operation in progress |
| host_done | output | 1 | One-cycle completion pulse |
| dg_clk | output | 1 | Serial clock to the dongle |
| dg_dout | output | 1 | Serial data to the dongle |
| dg_din | input | 1 | Serial data from the dongle |
| dg_rvalid_n | input | 1 | Active-low read-valid acknowledgement |

## Verification
host_busy must be high at the first falling edge after the strobe edge. The command and data results are checked against a pulse stream that is recorded at every rising edge of dg_clk. host_rdata and host_done are checked at the falling edge where host_done is seen, and the link is checked idle there too. The next falling edge must show host_done low again. The bench's dongle model changes dg_din and dg_rvalid_n only right after a rising edge of dg_clk. That gives at least three time units before the end-of-low-phase sample, which is more than the two synchronizer cycles, so the acknowledgement slot and each data bit can be predicted exactly. Pulse high width and pulse period are measured in system clocks and compared with cfg_presc+1 and three times that.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 5;
    localparam logic [BYTE_W-1:0] DEV_BASE = 8'h40;

    localparam int SEARCH_MAX = 10;
    localparam int DUMMY_N    = 2;
    localparam int WTAIL_N    = 2;
    localparam int RTAIL_HI_N = 1;
    localparam int RTAIL_LO_N = 3;
    localparam int RESET_N    = 30;

    localparam int SETUP_STEPS = 5;
    localparam logic [BYTE_W-1:0] SETUP_VAL0 = 8'h17;
    localparam logic [BYTE_W-1:0] SETUP_VAL2 = 8'hFF;
    localparam logic [IDX_W-1:0]  MODE_IDX   = 5'd1;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RESET = 2'b10,
        OP_SETUP = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_CMD,
        PH_WDATA,
        PH_WTAIL,
        PH_SEARCH,
        PH_RDATA,
        PH_DUMMY,
        PH_RTAIL_HI,
        PH_RTAIL_LO,
        PH_RESET
    } phase_e;

    typedef struct packed {
        op_e                op;
        logic [IDX_W-1:0]   idx;
        logic [BYTE_W-1:0]  wdata;
    } xfer_req_t;

    // address base | index in bits 5:1 | direction in bit 0
    function automatic logic [BYTE_W-1:0] cmd_byte(input logic [IDX_W-1:0] idx,
                                                   input logic wr);
        return DEV_BASE | {{(BYTE_W-IDX_W-1){1'b0}}, idx, wr};
    endfunction

    function automatic int slot_limit(input phase_e ph);
        case (ph)
            PH_CMD, PH_WDATA, PH_RDATA: return BYTE_W;
            PH_WTAIL:                   return WTAIL_N;
            PH_SEARCH:                  return SEARCH_MAX;
            PH_DUMMY:                   return DUMMY_N;
            PH_RTAIL_HI:                return RTAIL_HI_N;
            PH_RTAIL_LO:                return RTAIL_LO_N;
            PH_RESET:                   return RESET_N;
            default:                    return 1;
        endcase
    endfunction

    function automatic xfer_req_t setup_step(input int step,
                                             input logic [BYTE_W-1:0] mode);
        xfer_req_t r;
        case (step)
            0:       r = '{op: OP_RESET, idx: '0,       wdata: '0};
            1:       r = '{op: OP_WRITE, idx: 5'd0,     wdata: SETUP_VAL0};
            2:       r = '{op: OP_WRITE, idx: MODE_IDX, wdata: mode};
            3:       r = '{op: OP_WRITE, idx: 5'd2,     wdata: SETUP_VAL2};
            default: r = '{op: OP_READ,  idx: MODE_IDX, wdata: '0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dcfg_sync.sv
module dcfg_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfg_tick.sv
module dcfg_tick #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)   cnt <= presc;
        else if (cnt == '0)   cnt <= presc;
        else                  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> (cnt == $past(presc))) else $error("unit reload"); // R2
endmodule

// File: rtl/dcfg_xfer.sv
module dcfg_xfer
    import dcfg_pkg::*;
#(
    parameter int CNT_W = $clog2(RESET_N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              tick,
    input  xfer_req_t         req,
    input  logic              sdi_s,
    input  logic              rvn_s,
    output logic              sclk,
    output logic              sdo,
    output logic              fin,
    output logic [BYTE_W-1:0] rbyte
);
    phase_e             phase, nphase;
    logic [CNT_W-1:0]   bcnt, nbcnt;
    logic [1:0]         unit;
    logic [BYTE_W-1:0]  cmd_q, wd_q, rsh;
    logic               found, is_wr, nsdo, last;

    assign last  = (bcnt == CNT_W'(slot_limit(phase) - 1));
    assign rbyte = rsh;

    // next slot selection, evaluated at the end of a slot's high phase
    always_comb begin
        nphase = phase;
        nbcnt  = bcnt + 1'b1;
        nsdo   = sdo;
        if (phase == PH_SEARCH && found) begin
            nphase = PH_RDATA;
            nbcnt  = '0;
            nsdo   = 1'b1;
        end else if (!last) begin
            case (phase)
                PH_CMD:   nsdo = cmd_q[nbcnt[2:0]];
                PH_WDATA: nsdo = wd_q[nbcnt[2:0]];
                default:  nsdo = sdo;
            endcase
        end else begin
            nbcnt = '0;
            case (phase)
                PH_START: begin
                    nphase = PH_CMD;
                    nsdo   = cmd_q[0];
                end
                PH_CMD: begin
                    if (is_wr) begin
                        nphase = PH_WDATA;
                        nsdo   = wd_q[0];
                    end else begin
                        nphase = PH_SEARCH;
                        nsdo   = 1'b1;
                    end
                end
                PH_WDATA: begin
                    nphase = PH_WTAIL;
                    nsdo   = 1'b0;
                end
                PH_SEARCH: begin
                    nphase = PH_DUMMY;
                    nsdo   = 1'b1;
                end
                PH_RDATA, PH_DUMMY: begin
                    nphase = PH_RTAIL_HI;
                    nsdo   = 1'b1;
                end
                PH_RTAIL_HI: begin
                    nphase = PH_RTAIL_LO;
                    nsdo   = 1'b0;
                end
                default: begin
                    nphase = PH_IDLE;
                    nsdo   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            bcnt  <= '0;
            unit  <= '0;
            sclk  <= 1'b0;
            sdo   <= 1'b0;
            fin   <= 1'b0;
            cmd_q <= '0;
            wd_q  <= '0;
            rsh   <= '0;
            found <= 1'b0;
            is_wr <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (phase == PH_IDLE) begin
                if (go) begin
                    phase <= (req.op == OP_RESET) ? PH_RESET : PH_START;
                    is_wr <= (req.op == OP_WRITE);
                    cmd_q <= cmd_byte(req.idx, req.op == OP_WRITE);
                    wd_q  <= req.wdata;
                    bcnt  <= '0;
                    unit  <= '0;
                    sclk  <= 1'b0;
                    sdo   <= 1'b0;
                    rsh   <= '0;
                    found <= 1'b0;
                end
            end else if (tick) begin
                case (unit)
                    2'd0: unit <= 2'd1;
                    2'd1: begin
                        unit <= 2'd2;
                        sclk <= 1'b1;
                        if (phase == PH_SEARCH && !rvn_s) found <= 1'b1;
                        if (phase == PH_RDATA) rsh <= {sdi_s, rsh[BYTE_W-1:1]};
                    end
                    default: begin
                        unit  <= 2'd0;
                        sclk  <= 1'b0;
                        phase <= nphase;
                        bcnt  <= nbcnt;
                        sdo   <= nsdo;
                        if (nphase == PH_IDLE) fin <= 1'b1;
                    end
                endcase
            end
        end
    end

    AST_IDLE_LINK_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!sclk && !sdo)) else $error("link not idle"); // R4
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdo)) else $error("data moved while clock high"); // R2
    AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEARCH) |-> (bcnt < CNT_W'(SEARCH_MAX))) else $error("search overrun"); // R5
    AST_NOACK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DUMMY) |-> (rsh == '0)) else $error("dummy path data"); // R6
    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin) else $error("fin too long"); // R10
endmodule

// File: rtl/dcfg_seq.sv
module dcfg_seq
    import dcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              x_fin,
    input  logic [BYTE_W-1:0] x_rbyte,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rdata,
    output logic              x_go,
    output xfer_req_t         x_req
);
    localparam int STEP_W = $clog2(SETUP_STEPS);

    op_e               op_q;
    logic [BYTE_W-1:0] mode_q;
    logic [STEP_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            rdata  <= '0;
            x_go   <= 1'b0;
            x_req  <= '{op: OP_READ, idx: '0, wdata: '0};
            op_q   <= OP_READ;
            mode_q <= '0;
            step   <= '0;
        end else begin
            done <= 1'b0;
            x_go <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    x_go   <= 1'b1;
                    op_q   <= op_e'(op);
                    mode_q <= wdata;
                    step   <= '0;
                    if (op_e'(op) == OP_SETUP) x_req <= setup_step(0, wdata);
                    else                       x_req <= '{op: op_e'(op), idx: idx, wdata: wdata};
                end
            end else if (x_fin) begin
                if (op_q == OP_SETUP && int'(step) != SETUP_STEPS - 1) begin
                    step  <= step + 1'b1;
                    x_req <= setup_step(int'(step) + 1, mode_q);
                    x_go  <= 1'b1;
                end else begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (x_req.op == OP_READ) rdata <= x_rbyte;
                end
            end
        end
    end

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))) else $error("done without busy end"); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(op_q) && $stable(mode_q))) else $error("start taken while busy"); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> (done && x_req.op == OP_READ)) else $error("rdata moved"); // R12
    AST_SETUP_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(step) < SETUP_STEPS)) else $error("setup step range"); // R9
endmodule

// File: rtl/dcfg_master.sv
module dcfg_master
    import dcfg_pkg::*;
#(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic               host_start,
    input  logic [1:0]         host_op,
    input  logic [4:0]         host_idx,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               host_busy,
    output logic               host_done,
    output logic               dg_clk,
    output logic               dg_dout,
    input  logic               dg_din,
    input  logic               dg_rvalid_n
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] sync_q;
    logic              x_go, x_fin, tick;
    xfer_req_t         x_req;
    logic [BYTE_W-1:0] x_rbyte;

    // bit 1: read-valid (idles high), bit 0: data
    dcfg_sync #(.W(SYNC_W), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dg_rvalid_n, dg_din}),
        .q   (sync_q)
    );

    dcfg_tick #(.PRESC_W(PRESC_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (x_go),
        .presc   (cfg_presc),
        .tick    (tick)
    );

    dcfg_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (host_start),
        .op      (host_op),
        .idx     (host_idx),
        .wdata   (host_wdata),
        .x_fin   (x_fin),
        .x_rbyte (x_rbyte),
        .busy    (host_busy),
        .done    (host_done),
        .rdata   (host_rdata),
        .x_go    (x_go),
        .x_req   (x_req)
    );

    dcfg_xfer u_xfer (
        .clk   (clk),
        .rst   (rst),
        .go    (x_go),
        .tick  (tick),
        .req   (x_req),
        .sdi_s (sync_q[0]),
        .rvn_s (sync_q[1]),
        .sclk  (dg_clk),
        .sdo   (dg_dout),
        .fin   (x_fin),
        .rbyte (x_rbyte)
    );

    AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        dg_clk |-> host_busy) else $error("clock outside busy"); // R10
endmodule

// File: tb/dcfg_master_bench.sv
module dcfg_master_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_presc = 8'd0;
    logic       host_start = 1'b0;
    logic [1:0] host_op = 2'b00;
    logic [4:0] host_idx = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_busy, host_done, dg_clk, dg_dout;
    logic       dg_din = 1'b0;
    logic       dg_rvalid_n = 1'b1;

    always #2 clk = ~clk;

    dcfg_master u_dcfg_master (
        .clk(clk), .rst(rst), .cfg_presc(cfg_presc),
        .host_start(host_start), .host_op(host_op), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_busy(host_busy), .host_done(host_done),
        .dg_clk(dg_clk), .dg_dout(dg_dout),
        .dg_din(dg_din), .dg_rvalid_n(dg_rvalid_n)
    );

    int checks = 0;
    int fails  = 0;

    // link monitor and dongle model
    int   cyc = 0;
    logic cap [256];
    int   cap_n = 0;
    logic prev_sclk = 1'b0;
    int   last_rise = 0, period = 0, hw = 0;
    logic rd_on = 1'b0;
    int   rd_base = 0, ack_k = 0;
    logic [7:0] resp = '0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        int rel;
        if (dg_clk && !prev_sclk) begin
            if (cap_n < 256) cap[cap_n] = dg_dout;
            cap_n++;
            period = cyc - last_rise;
            last_rise = cyc;
        end
        if (!dg_clk && prev_sclk) hw = cyc - last_rise;
        prev_sclk = dg_clk;
        rel = cap_n - rd_base;
        dg_rvalid_n = !(rd_on && rel >= 9 + ack_k);
        if (rd_on && rel >= 10 + ack_k && rel < 18 + ack_k) dg_din = resp[rel - 10 - ack_k];
        else dg_din = 1'b0;
    end

    // expected pulse stream
    logic exp_b [256];
    int   exp_n = 0;

    task automatic e_push(input logic b);
        if (exp_n < 256) exp_b[exp_n] = b;
        exp_n++;
    endtask
    task automatic e_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) e_push(v[i]);
    endtask
    function automatic logic [7:0] cmdv(input logic [4:0] idx, input logic wr);
        return 8'h40 | (8'(idx) << 1) | 8'(wr);
    endfunction
    task automatic e_write(input logic [4:0] idx, input logic [7:0] d);
        e_push(1'b0); e_byte(cmdv(idx, 1'b1)); e_byte(d); e_push(1'b0); e_push(1'b0);
    endtask
    task automatic e_read(input logic [4:0] idx, input int k);
        rd_base = exp_n;
        e_push(1'b0); e_byte(cmdv(idx, 1'b0));
        if (k < 10) begin
            for (int i = 0; i <= k; i++) e_push(1'b1);
            for (int i = 0; i < 8; i++) e_push(1'b1);
        end else begin
            for (int i = 0; i < 12; i++) e_push(1'b1);
        end
        e_push(1'b1);
        for (int i = 0; i < 3; i++) e_push(1'b0);
    endtask
    task automatic e_reset();
        for (int i = 0; i < 30; i++) e_push(1'b0);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (host_done) begin seen = 1'b1; break; end
        end
        if (!seen) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [4:0] idx, input logic [7:0] wd);
        @(negedge clk);
        host_op = op; host_idx = idx; host_wdata = wd; host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        check(host_busy == 1'b1, "R10 busy after start", int'(host_busy), 1);
    endtask

    task automatic cmp_stream(input string req);
        int bad = -1;
        for (int i = 0; i < exp_n && i < 256; i++)
            if (bad < 0 && cap[i] !== exp_b[i]) bad = i;
        check(cap_n == exp_n && bad < 0, req, cap_n, exp_n);
        if (bad >= 0) $display("  first stream mismatch at pulse %0d", bad);
    endtask

    task automatic run(input logic [1:0] op, input logic [4:0] idx, input logic [7:0] wd,
                       input int k, input logic [7:0] rsp, input logic [7:0] pr,
                       input logic [7:0] exp_rd, input string req);
        bit seen;
        cfg_presc = pr;
        exp_n = 0; cap_n = 0; rd_base = 1000; rd_on = 1'b0;
        ack_k = k; resp = rsp;
        case (op)
            2'b00: begin e_read(idx, k); rd_on = 1'b1; end
            2'b01: e_write(idx, wd);
            2'b10: e_reset();
            default: begin
                e_reset(); e_write(5'd0, 8'h17); e_write(5'd1, wd); e_write(5'd2, 8'hFF);
                e_read(5'd1, k); rd_on = 1'b1;
            end
        endcase
        issue(op, idx, wd);
        wait_done(seen);
        if (seen) begin
            check(host_rdata == exp_rd, {req, " rdata (R12)"}, host_rdata, exp_rd);
            check(!dg_clk && !dg_dout, "R4 R7 link idle at done", {dg_clk, dg_dout}, 0);
            @(negedge clk);
            check(!host_done && !host_busy, "R10 done one cycle", {host_done, host_busy}, 0);
            cmp_stream({req, " pulse stream"});
        end
    endtask

    typedef struct packed {
        logic [1:0] op;
        logic [4:0] idx;
        logic [7:0] wd;
        logic [4:0] k;
        logic [7:0] rsp;
        logic [7:0] pr;
        logic [7:0] exp_rd;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'b01, 5'd3,  8'hA5, 5'd0,  8'h00, 8'd0, 8'h00},  // write, R1 R3 R4 R13
        '{2'b00, 5'd3,  8'h00, 5'd0,  8'h3C, 8'd1, 8'h3C},  // read, ack at first check, R5 R14
        '{2'b00, 5'd31, 8'h00, 5'd9,  8'hC3, 8'd0, 8'hC3},  // read, ack at last check, R5 R7
        '{2'b01, 5'd31, 8'h5E, 5'd0,  8'h00, 8'd2, 8'hC3},  // write keeps rdata, R12
        '{2'b10, 5'd0,  8'h00, 5'd0,  8'h00, 8'd0, 8'hC3},  // dongle reset, R8
        '{2'b00, 5'd0,  8'h00, 5'd15, 8'hFF, 8'd1, 8'h00},  // no acknowledgement, R6
        '{2'b11, 5'd0,  8'h42, 5'd3,  8'h81, 8'd0, 8'h81}   // mode setup, R9
    };

    initial begin
        string tags [7] = '{"R1 R3 R4 R13 write", "R5 R14 read", "R5 R7 read late ack",
                            "R4 R12 write", "R8 reset", "R6 R7 no ack", "R9 setup"};
        bit seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!host_busy && !host_done && !dg_clk && !dg_dout && host_rdata == 8'h00,
              "R12 reset state", {host_busy, host_done, dg_clk, dg_dout}, 0);

        for (int v = 0; v < 7; v++)
            run(VECS[v].op, VECS[v].idx, VECS[v].wd, int'(VECS[v].k), VECS[v].rsp,
                VECS[v].pr, VECS[v].exp_rd, tags[v]);

        // R2: slot timing with a unit of 4 system clocks
        run(2'b01, 5'd9, 8'h6B, 0, 8'h00, 8'd3, 8'h81, "R2 write slow");
        check(hw == 4, "R2 high width", hw, 4);
        check(period == 12, "R2 pulse period", period, 12);

        // R11: a strobe while busy is ignored
        cfg_presc = 8'd0;
        exp_n = 0; cap_n = 0; rd_on = 1'b0; rd_base = 1000;
        e_write(5'd4, 8'h99);
        issue(2'b01, 5'd4, 8'h99);
        repeat (10) @(negedge clk);
        host_op = 2'b00; host_idx = 5'd7; host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        wait_done(seen);
        if (seen) begin
            check(host_rdata == 8'h81, "R11 rdata unchanged", host_rdata, 8'h81);
            @(negedge clk);
            repeat (5) @(negedge clk);
            check(!host_busy && cap_n == 19, "R11 no extra transfer", cap_n, 19);
            cmp_stream("R11 stream is the write only");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule